// File: doc/BRIEF.md
# Partial-Field Word Load/Store Unit

This unit reads and writes selected bytes of a sign-magnitude word. A word has a sign bit and five 6-bit bytes, with byte 1 the most significant. A 6-bit field code picks a contiguous byte range, left position `L` through right position `R`. Position 0 stands for the sign.

A load takes the chosen bytes of a memory word and places them right-justified in a register value. The sign is carried only when the field begins at position 0. A negated load flips the sign as its last step. A store merges the low-order bytes of a source value into the chosen positions of the memory word and leaves every other byte as it was. The source is the register bus for a plain store, all zeros for store-zero, and the jump address with a positive sign for store-jump.

The unit also checks that the address lies inside memory and that the field code is legal. It flags a load into a narrow index register when the loaded value does not fit in two bytes.

Requests use a valid/ready handshake. The unit accepts a request when `req_valid` and `req_ready` are both high at a clock edge, and the request fields must hold steady while `req_valid` waits for `req_ready`. During the accept cycle the unit drives `mem_rd_addr` combinationally, and the surrounding memory must return `mem_rdata` in that same cycle. On the next cycle `done` pulses together with the write strobes and the error flags. `req_ready` is low during the `done` cycle. This guarantees that a following read observes a store that has just landed.

Top module: `fls_unit`

## Requirements
- R1: The field code `F` encodes `L = F[5:3]` and `R = F[2:0]`. It is legal only when `L <= R <= 5`. For a known operation, an illegal code raises `err_field` in the `done` cycle and suppresses both `reg_we` and `mem_we`.
- R2: A load (`req_op` 0) selects bytes `max(L,1)` through `R` of `mem_rdata`. It returns them right-justified in `reg_rdata[29:0]`, clears all higher bytes, and asserts `reg_we`. Byte 1 occupies bits 29:24 and byte 5 occupies bits 5:0.
- R3: A load copies the memory sign (bit 30, 1 = negative) only when `L = 0`. Otherwise the loaded sign is 0, meaning positive.
- R4: A negated load (`req_op` 1) gives the same magnitude as R2 and the inverse of the sign that R3 would give.
- R5: A store (`req_op` 2) places the `R - max(L,1) + 1` least significant bytes of `reg_wdata` into positions `max(L,1)..R` of the memory word, keeping their order. It leaves all other bytes unchanged. It writes the register sign only when `L = 0`. The merged word is driven on `mem_wdata` with `mem_we`.
- R6: Store-zero (`req_op` 3) writes zero bytes into the field. It writes a positive sign when `L = 0` and otherwise keeps the memory sign.
- R7: Store-jump (`req_op` 4) stores, as in R5, a source word made of `jump_addr` zero-extended and given a positive sign.
- R8: An address `req_addr` is read as a two's complement value. When it is negative or above 3999, a known operation raises `err_addr` and writes nothing. `mem_rd_addr` always equals the low 12 bits of `req_addr`, and `mem_wr_addr` equals that same value in the `done` cycle.
- R9: A load or negated load with `req_idx_dst` high raises `err_reg` and withholds `reg_we` when any of loaded bytes 1 to 3 is nonzero.
- R10: `done` pulses exactly one cycle after each accepted request. `req_ready` is low in that cycle and high in every other cycle after reset. After reset, `done`, both write strobes and all error flags are low.
- R11: The reserved operation codes 5, 6 and 7 complete with `done`, raise no error and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 3 | Operation: 0 load, 1 negated load, 2 store, 3 store-zero, 4 store-jump |
| req_field | input | 6 | Field code, 8*L + R |
| req_addr | input | 13 | Two's complement memory address |
| req_idx_dst | input | 1 | Load destination is a two-byte index register |
| reg_wdata | input | 31 | Register value to store (sign in bit 30) |
| jump_addr | input | 12 | Jump-address register for store-jump |
| mem_rd_addr | output | 12 | Read address, valid in the accept cycle |
| mem_rdata | input | 31 | Memory word read in the accept cycle |
| done | output | 1 | Operation complete, one cycle after accept |
| reg_we | output | 1 | Register write strobe |
| reg_rdata | output | 31 | Loaded register value |
| mem_we | output | 1 | Memory write strobe |
| mem_wr_addr | output | 12 | Memory write address |
| mem_wdata | output | 31 | Merged word to write |
| err_field | output | 1 | Illegal field code |
| err_addr | output | 1 | Address out of range |
| err_reg | output | 1 | Index register overflow |

## Verification
`mem_rd_addr` depends combinationally on the request. The bench therefore checks it in the accept cycle, after the inputs have settled and before the clock edge that accepts them. Every other result (`done`, the strobes, the data and the three error flags) is registered once and falls due exactly one cycle after the accept. The bench drives a request on a falling edge and samples all of these outputs on the next falling edge. At that same point it also confirms that `req_ready` is low. It then spends one idle cycle, so that each request's results are sampled in their own `done` window and nowhere else.

// File: rtl/fls_pkg.sv
package fls_pkg;
  parameter int BYTE_W  = 6;
  parameter int NBYTES  = 5;
  parameter int MAG_W   = BYTE_W * NBYTES;
  parameter int WORD_W  = MAG_W + 1;
  parameter int FCODE_W = 6;
  parameter int POS_W   = 3;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_LOADN = 3'd1,
    OP_STORE = 3'd2,
    OP_STZ   = 3'd3,
    OP_STJ   = 3'd4
  } op_e;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
  } word_t;
endpackage

// File: rtl/fls_field_decode.sv
module fls_field_decode
  import fls_pkg::*;
(
  input  logic [FCODE_W-1:0] fcode,
  output logic               legal,
  output logic               sign_sel,
  output logic [POS_W-1:0]   shamt,
  output logic [MAG_W-1:0]   mask
);
  logic [POS_W-1:0] lft, rgt, lo;

  assign lft      = fcode[FCODE_W-1 -: POS_W];
  assign rgt      = fcode[POS_W-1:0];
  assign lo       = (lft == '0) ? POS_W'(1) : lft;
  assign legal    = (lft <= rgt) && (rgt <= POS_W'(NBYTES));
  assign sign_sel = (lft == '0);
  assign shamt    = POS_W'(NBYTES) - rgt;

  // One byte-enable lane per byte position, byte 1 on the top bits.
  for (genvar b = 1; b <= NBYTES; b++) begin : g_lane
    assign mask[(NBYTES-b)*BYTE_W +: BYTE_W] =
      {BYTE_W{legal && (POS_W'(b) >= lo) && (POS_W'(b) <= rgt)}};
  end
endmodule

// File: rtl/fls_load_path.sv
module fls_load_path
  import fls_pkg::*;
(
  input  word_t            mem,
  input  logic [MAG_W-1:0] mask,
  input  logic [POS_W-1:0] shamt,
  input  logic             sign_sel,
  input  logic             negate,
  output word_t            res
);
  always_comb begin
    res.mag  = (mem.mag & mask) >> (int'(shamt) * BYTE_W);
    res.sign = (sign_sel ? mem.sign : 1'b0) ^ negate;
  end
endmodule

// File: rtl/fls_store_path.sv
module fls_store_path
  import fls_pkg::*;
(
  input  word_t            mem,
  input  word_t            src,
  input  logic [MAG_W-1:0] mask,
  input  logic [POS_W-1:0] shamt,
  input  logic             sign_sel,
  output word_t            res
);
  logic [MAG_W-1:0] aligned;

  always_comb begin
    aligned  = src.mag << (int'(shamt) * BYTE_W);
    res.mag  = (mem.mag & ~mask) | (aligned & mask);
    res.sign = sign_sel ? src.sign : mem.sign;
  end
endmodule

// File: rtl/fls_unit.sv
module fls_unit
  import fls_pkg::*;
#(
  parameter int MEM_WORDS = 4000,
  parameter int ADDR_W    = 13,
  parameter int IDX_BYTES = 2,
  parameter int JADDR_W   = 12,
  localparam int MA_W     = $clog2(MEM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2:0]           req_op,
  input  logic [FCODE_W-1:0]   req_field,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_idx_dst,
  input  logic [WORD_W-1:0]    reg_wdata,
  input  logic [JADDR_W-1:0]   jump_addr,
  output logic [MA_W-1:0]      mem_rd_addr,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 done,
  output logic                 reg_we,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 mem_we,
  output logic [MA_W-1:0]      mem_wr_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  output logic                 err_field,
  output logic                 err_addr,
  output logic                 err_reg
);
  localparam int IDX_BITS = IDX_BYTES * BYTE_W;

  logic             accept, legal, sign_sel, addr_bad;
  logic             is_ld, is_st, known, e_field, e_addr, e_reg, ok;
  logic [POS_W-1:0] shamt;
  logic [MAG_W-1:0] mask;
  word_t            ld_res, st_res, st_src;

  assign accept      = req_valid && req_ready;
  assign req_ready   = !done;
  assign mem_rd_addr = req_addr[MA_W-1:0];
  assign addr_bad    = req_addr[ADDR_W-1] || (req_addr >= ADDR_W'(MEM_WORDS));

  assign is_ld = (req_op == OP_LOAD) || (req_op == OP_LOADN);
  assign is_st = (req_op == OP_STORE) || (req_op == OP_STZ) || (req_op == OP_STJ);
  assign known = is_ld || is_st;

  always_comb begin
    unique case (req_op)
      OP_STORE: st_src = word_t'(reg_wdata);
      OP_STJ:   st_src = '{sign: 1'b0, mag: MAG_W'(jump_addr)};
      default:  st_src = '0;
    endcase
  end

  fls_field_decode u_dec (
    .fcode(req_field), .legal(legal), .sign_sel(sign_sel),
    .shamt(shamt), .mask(mask)
  );

  fls_load_path u_ld (
    .mem(word_t'(mem_rdata)), .mask(mask), .shamt(shamt),
    .sign_sel(sign_sel), .negate(req_op == OP_LOADN), .res(ld_res)
  );

  fls_store_path u_st (
    .mem(word_t'(mem_rdata)), .src(st_src), .mask(mask), .shamt(shamt),
    .sign_sel(sign_sel), .res(st_res)
  );

  assign e_field = known && !legal;
  assign e_addr  = known && addr_bad;
  assign e_reg   = is_ld && req_idx_dst && (|ld_res.mag[MAG_W-1:IDX_BITS]);
  assign ok      = !(e_field || e_addr || e_reg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      reg_we      <= 1'b0;
      mem_we      <= 1'b0;
      err_field   <= 1'b0;
      err_addr    <= 1'b0;
      err_reg     <= 1'b0;
      reg_rdata   <= '0;
      mem_wdata   <= '0;
      mem_wr_addr <= '0;
    end else begin
      done      <= accept;
      reg_we    <= accept && is_ld && ok;
      mem_we    <= accept && is_st && ok;
      err_field <= accept && e_field;
      err_addr  <= accept && e_addr;
      err_reg   <= accept && e_reg;
      if (accept) begin
        reg_rdata   <= ld_res;
        mem_wdata   <= st_res;
        mem_wr_addr <= req_addr[MA_W-1:0];
      end
    end
  end

  // Timing of the completion pulse (R10)
  p_done_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> done);
  p_ready_low_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // Strobes only in the completion cycle
  p_strobe_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || mem_we) |-> done);
  // Error gating (R1, R8, R9)
  p_field_err_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_field |-> !reg_we && !mem_we);
  p_addr_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_addr |-> !reg_we && !mem_we);
  p_idx_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_reg |-> !reg_we);
  // Sign handling (R3, R5)
  p_load_sign_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept && req_op == OP_LOAD && req_field[5:3] != 3'd0) |->
      !reg_rdata[WORD_W-1]);
  p_store_keeps_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept && is_st && req_field[5:3] != 3'd0) && mem_we |->
      mem_wdata[WORD_W-1] == $past(mem_rdata[WORD_W-1]));
  // Reserved codes (R11)
  p_reserved_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept && !known) |-> !reg_we && !mem_we && !err_field && !err_addr && !err_reg);
endmodule

// File: tb/fls_unit_bench.sv
module fls_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [5:0]  req_field = '0;
  logic [12:0] req_addr = '0;
  logic        req_idx_dst = 1'b0;
  logic [30:0] reg_wdata = '0;
  logic [11:0] jump_addr = '0;
  logic [11:0] mem_rd_addr;
  logic [30:0] mem_rdata = '0;
  logic        done, reg_we, mem_we, err_field, err_addr, err_reg;
  logic [30:0] reg_rdata, mem_wdata;
  logic [11:0] mem_wr_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fls_unit u_fls_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_field(req_field), .req_addr(req_addr),
    .req_idx_dst(req_idx_dst), .reg_wdata(reg_wdata), .jump_addr(jump_addr),
    .mem_rd_addr(mem_rd_addr), .mem_rdata(mem_rdata), .done(done),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .mem_we(mem_we),
    .mem_wr_addr(mem_wr_addr), .mem_wdata(mem_wdata),
    .err_field(err_field), .err_addr(err_addr), .err_reg(err_reg)
  );

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [5:0] byte_of(input logic [30:0] w, input int p);
    return w[29 - 6*(p-1) -: 6];
  endfunction

  // Reference model built from the requirements.
  task automatic model(input logic [2:0] op, input logic [5:0] f, input logic [12:0] a,
                       input logic idx, input logic [30:0] rw, input logic [11:0] ja,
                       input logic [30:0] mw,
                       output logic e_f, output logic e_a, output logic e_r,
                       output logic rwe, output logic mwe,
                       output logic [30:0] ld, output logic [30:0] st);
    int l, r, lo, k;
    logic [30:0] src;
    bit ldop, stop;
    l = int'(f[5:3]); r = int'(f[2:0]);
    lo = (l == 0) ? 1 : l;
    ldop = (op == 3'd0) || (op == 3'd1);
    stop = (op >= 3'd2) && (op <= 3'd4);
    e_f = (ldop || stop) && !((l <= r) && (r <= 5));
    e_a = (ldop || stop) && ($signed(a) < 0 || $signed(a) > 3999);
    ld = '0;
    st = mw;
    if (!e_f) begin
      for (int p = lo; p <= r; p++) ld[29:0] = (ld[29:0] << 6) | 30'(byte_of(mw, p));
      ld[30] = ((l == 0) ? mw[30] : 1'b0) ^ (op == 3'd1);
      src = (op == 3'd2) ? rw : (op == 3'd4) ? {19'd0, ja} : 31'd0;
      k = 0;
      for (int p = r; p >= lo; p--) begin
        st[29 - 6*(p-1) -: 6] = byte_of(src, 5 - k);
        k++;
      end
      if (l == 0) st[30] = src[30];
    end
    e_r = ldop && idx && !e_f && (ld[29:12] != 18'd0);
    rwe = ldop && !(e_f || e_a || e_r);
    mwe = stop && !(e_f || e_a);
  endtask

  task automatic run(input logic [2:0] op, input logic [5:0] f, input logic [12:0] a,
                     input logic idx, input logic [30:0] rw, input logic [11:0] ja,
                     input logic [30:0] mw);
    logic e_f, e_a, e_r, rwe, mwe;
    logic [30:0] ld, st;
    string dtag;
    model(op, f, a, idx, rw, ja, mw, e_f, e_a, e_r, rwe, mwe, ld, st);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_field = f; req_addr = a;
    req_idx_dst = idx; reg_wdata = rw; jump_addr = ja; mem_rdata = mw;
    #1;
    chk(req_ready == 1'b1, "R10", "ready before accept", 32'(req_ready), 32'd1);
    chk(mem_rd_addr == a[11:0], "R8", "read address", 32'(mem_rd_addr), 32'(a[11:0]));
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b1, "R10", "done pulse", 32'(done), 32'd1);
    chk(req_ready == 1'b0, "R10", "ready in done", 32'(req_ready), 32'd0);
    chk(err_field == e_f, "R1", "err_field", 32'(err_field), 32'(e_f));
    chk(err_addr == e_a, "R8", "err_addr", 32'(err_addr), 32'(e_a));
    chk(err_reg == e_r, "R9", "err_reg", 32'(err_reg), 32'(e_r));
    chk(reg_we == rwe, (op > 3'd4) ? "R11" : "R2", "reg_we", 32'(reg_we), 32'(rwe));
    chk(mem_we == mwe, (op > 3'd4) ? "R11" : "R5", "mem_we", 32'(mem_we), 32'(mwe));
    if (rwe) begin
      chk(reg_rdata[29:0] == ld[29:0], "R2", "load magnitude", 32'(reg_rdata[29:0]), 32'(ld[29:0]));
      chk(reg_rdata[30] == ld[30], (op == 3'd1) ? "R4" : "R3", "load sign",
          32'(reg_rdata[30]), 32'(ld[30]));
    end
    if (mwe) begin
      dtag = (op == 3'd3) ? "R6" : (op == 3'd4) ? "R7" : "R5";
      chk(mem_wdata == st, dtag, "stored word", 32'(mem_wdata), 32'(st));
      chk(mem_wr_addr == a[11:0], "R8", "write address", 32'(mem_wr_addr), 32'(a[11:0]));
    end
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R10", "idle after done",
        32'({done, req_ready}), 32'b01);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog expired: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [2:0] op;
    logic [5:0] f;
    logic [12:0] a;
    int l, r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(done == 0 && reg_we == 0 && mem_we == 0, "R10", "reset strobes",
        32'({done, reg_we, mem_we}), 32'd0);
    chk(err_field == 0 && err_addr == 0 && err_reg == 0, "R10", "reset errors",
        32'({err_field, err_addr, err_reg}), 32'd0);
    rst_n = 1'b1;
    // Directed corner cases
    run(3'd0, 6'd5,  13'd100, 0, '0, '0, 31'h5234_5678);  // R2 R3 full word with sign
    run(3'd0, 6'd13, 13'd101, 0, '0, '0, 31'h5234_5678);  // R3 sign dropped
    run(3'd0, 6'd0,  13'd102, 0, '0, '0, 31'h4000_0001);  // sign only
    run(3'd0, 6'd45, 13'd103, 0, '0, '0, 31'h3FFF_FFC1);  // byte 5 only
    run(3'd1, 6'd0,  13'd104, 0, '0, '0, 31'h0000_0000);  // R4 negated -0
    run(3'd1, 6'd19, 13'd105, 0, '0, '0, 31'h4ABC_DEF0);  // R4 (2:3)
    run(3'd2, 6'd0,  13'd106, 0, 31'h4000_0003, '0, 31'h1234_5678); // R5 sign only
    run(3'd2, 6'd11, 13'd107, 0, 31'h3FFF_FFFF, '0, 31'h4000_0000); // R5 (1:3)
    run(3'd3, 6'd5,  13'd108, 0, '0, '0, 31'h7FFF_FFFF);  // R6 full clear
    run(3'd3, 6'd18, 13'd109, 0, '0, '0, 31'h7FFF_FFFF);  // R6 (2:2), sign kept
    run(3'd4, 6'd37, 13'd110, 0, '0, 12'hABC, 31'h7FFF_FFFF); // R7 (4:5)
    run(3'd4, 6'd5,  13'd111, 0, '0, 12'h0FF, 31'h7FFF_FFFF); // R7 full
    run(3'd0, 6'd6,  13'd112, 0, '0, '0, 31'h1);          // R1 R>5
    run(3'd2, 6'd17, 13'd113, 0, 31'h5, '0, 31'h1);       // R1 L>R
    run(3'd0, 6'd5,  13'd4000, 0, '0, '0, 31'h1);         // R8 just past end
    run(3'd2, 6'd5,  13'h1FFF, 0, 31'h1, '0, 31'h1);      // R8 negative
    run(3'd2, 6'd5,  13'd3999, 0, 31'h7, '0, 31'h1);      // R8 last word
    run(3'd0, 6'd5,  13'd5, 1, '0, '0, 31'h0000_1000);    // R9 overflow
    run(3'd0, 6'd5,  13'd6, 1, '0, '0, 31'h4000_0FFF);    // R9 fits
    run(3'd0, 6'd37, 13'd7, 1, '0, '0, 31'h7FFF_FFFF);    // R9 (4:5) fits
    run(3'd5, 6'd7,  13'd8000, 0, '0, '0, 31'h1);         // R11 reserved
    run(3'd7, 6'd5,  13'd9, 0, '0, '0, 31'h1);            // R11 reserved
    // Constrained random
    for (int i = 0; i < 400; i++) begin
      op = ($urandom_range(0, 19) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
      l = $urandom_range(0, 5);
      r = $urandom_range(l, 5);
      f = ($urandom_range(0, 9) == 0) ? 6'($urandom) : 6'(8*l + r);
      a = ($urandom_range(0, 19) == 0) ? 13'($urandom) : 13'($urandom_range(0, 3999));
      run(op, f, a, 1'($urandom), 31'($urandom), 12'($urandom), 31'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule